// File: doc/BRIEF.md
# EPP Access Gating Controller

This block sits behind a parallel port's byte-wide register window and adds enhanced-parallel-port address and data cycles to the plain data, status and control registers. A bus master issues one access at a time. Offset 3 is the EPP address port and offset 4 is the EPP data port. Every transfer on those two offsets first passes a gate: it starts only if selected bits of the control register hold an exact pattern. The pattern differs for writes and reads. When the gate refuses, the access finishes at once: a write is lost and a read returns all ones.

An accepted transfer is moved to the peripheral one byte at a time over a request/acknowledge pair. The peripheral must acknowledge within a cycle limit that software can set. The data port takes 1, 2 and 4 byte accesses and moves the bytes least significant first. If a byte is not acknowledged in time, the bytes still to go are dropped and a sticky timeout flag is set. This flag takes the place of bit 0 in status reads, and only a status write clears it. The bus master is held off with a wait signal while a transfer runs.

Writes to the data and control registers are passed to the peripheral side as events, but only when they change the stored value. A change of the direction bit sends a separate direction event one cycle before the control event. A second window, selected by a separate input, reads 0xFF and ignores writes.

Top module: `epp_gate_ctrl`

## Requirements
- R1: After reset the control register reads 0xCC, the data register reads 0xFF, the timeout flag is clear, and no request or event is active.
- R2: An EPP write (offset 3 or 4) starts only when (control & 0x2F) == 0x04. Otherwise it completes in the cycle after acceptance with no peripheral request.
- R3: An EPP read starts only when (control & 0x2F) == 0x24. Otherwise it completes at once and returns ones in every byte lane of the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R4: Each byte raises pp_req and holds it with a stable pp_op and pp_wbyte. The request drops after a sampled pp_ack, or after tmo_limit cycles without one. pp_op codes: 0 address write, 1 data write, 2 address read, 3 data read.
- R5: A failed byte sets the timeout flag. A status write (offset 1) with bit 0 set clears it. A status write with bit 0 clear leaves it unchanged.
- R6: A status read returns pin_status[7:1] in bits 7:1 and the timeout flag in bit 0.
- R7: On the data port, acc_size 0, 1 and 2 (or 3) mean 1, 2 and 4 bytes. The bytes go least significant first, and read bytes are assembled little-endian. The address port always moves one byte.
- R8: After a failed byte, the remaining bytes are never requested. A failed read returns the bytes already received and ones in the lanes that were not received.
- R9: A data-register write (offset 0) with a new value sends an event of kind 0 carrying the byte. A write with an equal value sends no event. A read returns the stored value.
- R10: A control write stores the value with bits 7:6 forced to 1. If the stored value would not change, there is no event. Otherwise a kind 1 event carries the new value. When bit 5 (direction) changes, a kind 2 event carrying the new direction in bit 0 comes one cycle earlier.
- R11: With acc_win high, reads return 0xFF and writes change no register and send no event.
- R12: acc_wait is high from the cycle after a gated transfer or a direction-changing control write is accepted until it completes. It is low for every other access, and no request is active while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_limit | input | TMO_W | Acknowledge limit in cycles per byte (0 acts as 1) |
| acc_req | input | 1 | Access strobe, accepted while acc_wait is low |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_win | input | 1 | Selects the secondary window |
| acc_addr | input | 3 | Register offset |
| acc_size | input | 2 | Access width code for the data port |
| acc_wdata | input | 8*BUS_BYTES | Write data |
| acc_wait | output | 1 | Access in progress, new strobes ignored |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 8*BUS_BYTES | Read data, valid with acc_done |
| pin_status | input | 8 | Peripheral status lines |
| pp_req | output | 1 | Byte transfer request |
| pp_op | output | 2 | Transfer kind |
| pp_wbyte | output | 8 | Byte to write |
| pp_ack | input | 1 | Peripheral acknowledge |
| pp_rdata | input | 8 | Byte read, sampled with pp_ack |
| ev_valid | output | 1 | Register event strobe |
| ev_kind | output | 2 | 0 data, 1 control, 2 direction |
| ev_byte | output | 8 | Event payload |

## Verification
EPP accesses are tried under three control values: 0xCC, 0xC4 and 0xE4. This shows that the write gate and the read gate are two separate exact matches and not a single enable bit. Widths 1, 2 and 4 are used with a distinct byte in each lane, so the byte order and the width masking of gated-off reads can be told apart. The peripheral model can stop acknowledging after a chosen number of bytes. This separates a failure on the first byte from one in the middle, and the check that the request lasts exactly tmo_limit cycles pins down the timeout count. Control writes are sent with and without a direction change and with a repeated value, which makes the order of the events and the suppression of unchanged values visible.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
    localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
    localparam logic [7:0] WR_GATE_VAL    = 8'h04;
    localparam logic [7:0] RD_GATE_VAL    = 8'h24;
    localparam logic [7:0] CTRL_FIXED     = 8'hC0;
    localparam logic [7:0] CTRL_RST       = 8'hCC;
    localparam logic [7:0] DATA_RST       = 8'hFF;
    localparam int         DIR_BIT        = 5;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_EADDR = 3'd3;
    localparam logic [2:0] OFS_EDATA = 3'd4;

    typedef enum logic [1:0] {
        OP_WADDR = 2'd0,
        OP_WDATA = 2'd1,
        OP_RADDR = 2'd2,
        OP_RDATA = 2'd3
    } pp_op_e;

    typedef enum logic [1:0] {
        EV_DATA = 2'd0,
        EV_CTRL = 2'd1,
        EV_DIR  = 2'd2
    } ev_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CTRL = 2'd1,
        ST_XFER = 2'd2
    } st_e;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
    import epp_gate_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       rd,
    output logic       pass
);
    // Exact match of the masked control bits, different pattern per direction
    always_comb begin
        pass = ((ctrl & CTRL_GATE_MASK) == (rd ? RD_GATE_VAL : WR_GATE_VAL));
    end
endmodule

// File: rtl/epp_byte_xfer.sv
module epp_byte_xfer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [TMO_W-1:0] limit,
    input  logic             ack,
    input  logic [7:0]       rdata,
    output logic             req,
    output logic             fin,
    output logic             ok,
    output logic [7:0]       rbyte
);
    localparam int CW = TMO_W + 1;

    typedef struct packed {
        logic             busy;
        logic [TMO_W-1:0] cnt;
        logic             fin;
        logic             ok;
        logic [7:0]       rbyte;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.busy) begin
            if (launch) begin
                d.busy = 1'b1;
                d.cnt  = '0;
            end
        end else if (ack) begin
            d.busy  = 1'b0;
            d.fin   = 1'b1;
            d.ok    = 1'b1;
            d.rbyte = rdata;
        end else if (({1'b0, q.cnt} + CW'(1)) >= {1'b0, limit}) begin
            d.busy = 1'b0;
            d.fin  = 1'b1;
            d.ok   = 1'b0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req   = q.busy;
    assign fin   = q.fin;
    assign ok    = q.ok;
    assign rbyte = q.rbyte;
endmodule

// File: rtl/epp_gate_ctrl.sv
module epp_gate_ctrl
    import epp_gate_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int TMO_W     = 8,
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int IDX_W    = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             acc_req,
    input  logic             acc_write,
    input  logic             acc_win,
    input  logic [2:0]       acc_addr,
    input  logic [1:0]       acc_size,
    input  logic [BUS_W-1:0] acc_wdata,
    output logic             acc_wait,
    output logic             acc_done,
    output logic [BUS_W-1:0] acc_rdata,
    input  logic [7:0]       pin_status,
    output logic             pp_req,
    output logic [1:0]       pp_op,
    output logic [7:0]       pp_wbyte,
    input  logic             pp_ack,
    input  logic [7:0]       pp_rdata,
    output logic             ev_valid,
    output logic [1:0]       ev_kind,
    output logic [7:0]       ev_byte
);
    typedef struct packed {
        st_e              st;
        logic [7:0]       ctrl;
        logic [7:0]       data;
        logic [7:0]       pend;
        logic             tmo;
        logic             done;
        logic [BUS_W-1:0] rdata;
        logic [BUS_W-1:0] rbuf;
        logic [BUS_W-1:0] wbuf;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             rd;
        pp_op_e           op;
        logic             launch;
        logic             ev_valid;
        ev_kind_e         ev_kind;
        logic [7:0]       ev_byte;
    } top_t;

    localparam top_t RST_VAL = '{
        st: ST_IDLE, ctrl: CTRL_RST, data: DATA_RST, pend: 8'h00, tmo: 1'b0,
        done: 1'b0, rdata: '0, rbuf: '1, wbuf: '0, idx: '0, last: '0,
        rd: 1'b0, op: OP_WADDR, launch: 1'b0, ev_valid: 1'b0,
        ev_kind: EV_DATA, ev_byte: 8'h00
    };

    top_t q, d;

    logic       gate_pass;
    logic       eng_req, eng_fin, eng_ok;
    logic [7:0] eng_rbyte;
    logic [7:0] ctrl_reg;
    logic       tmo_flag;

    function automatic logic [IDX_W-1:0] last_of(input logic [1:0] sz);
        int n;
        n = 1 << sz;
        if (n > BUS_BYTES) n = BUS_BYTES;
        return IDX_W'(n - 1);
    endfunction

    function automatic logic [BUS_W-1:0] lane_ones(input logic [IDX_W-1:0] lst);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (i <= int'(lst)) m[8*i +: 8] = 8'hFF;
        end
        return m;
    endfunction

    epp_gate u_gate (
        .ctrl (q.ctrl),
        .rd   (~acc_write),
        .pass (gate_pass)
    );

    epp_byte_xfer #(.TMO_W(TMO_W)) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (q.launch),
        .limit  (tmo_limit),
        .ack    (pp_ack),
        .rdata  (pp_rdata),
        .req    (eng_req),
        .fin    (eng_fin),
        .ok     (eng_ok),
        .rbyte  (eng_rbyte)
    );

    always_comb begin
        logic [7:0]       wb;
        logic [7:0]       nv;
        logic [7:0]       stat;
        logic [IDX_W-1:0] lst;
        logic             is_data;
        logic [BUS_W-1:0] nb;

        d          = q;
        d.done     = 1'b0;
        d.launch   = 1'b0;
        d.ev_valid = 1'b0;
        wb         = acc_wdata[7:0];
        nv         = wb | CTRL_FIXED;
        stat       = pin_status;
        stat[0]    = q.tmo;
        is_data    = (acc_addr == OFS_EDATA);
        lst        = is_data ? last_of(acc_size) : '0;
        nb         = q.rbuf;

        case (q.st)
            ST_IDLE: begin
                if (acc_req) begin
                    d.done  = 1'b1;
                    d.rdata = '0;
                    if (acc_win) begin
                        if (!acc_write) d.rdata = BUS_W'(8'hFF);
                    end else begin
                        case (acc_addr)
                            OFS_DATA: begin
                                if (acc_write) begin
                                    if (wb != q.data) begin
                                        d.data     = wb;
                                        d.ev_valid = 1'b1;
                                        d.ev_kind  = EV_DATA;
                                        d.ev_byte  = wb;
                                    end
                                end else begin
                                    d.rdata = BUS_W'(q.data);
                                end
                            end
                            OFS_STAT: begin
                                if (acc_write) begin
                                    if (wb[0]) d.tmo = 1'b0;
                                end else begin
                                    d.rdata = BUS_W'(stat);
                                end
                            end
                            OFS_CTRL: begin
                                if (acc_write) begin
                                    if (nv != q.ctrl) begin
                                        d.ev_valid = 1'b1;
                                        if (nv[DIR_BIT] != q.ctrl[DIR_BIT]) begin
                                            d.ev_kind = EV_DIR;
                                            d.ev_byte = {7'b0, nv[DIR_BIT]};
                                            d.pend    = nv;
                                            d.st      = ST_CTRL;
                                            d.done    = 1'b0;
                                        end else begin
                                            d.ctrl    = nv;
                                            d.ev_kind = EV_CTRL;
                                            d.ev_byte = nv;
                                        end
                                    end
                                end else begin
                                    d.rdata = BUS_W'(q.ctrl);
                                end
                            end
                            OFS_EADDR, OFS_EDATA: begin
                                if (gate_pass) begin
                                    d.st     = ST_XFER;
                                    d.done   = 1'b0;
                                    d.launch = 1'b1;
                                    d.idx    = '0;
                                    d.last   = lst;
                                    d.rd     = ~acc_write;
                                    d.wbuf   = acc_wdata;
                                    d.rbuf   = '1;
                                    d.op     = acc_write ? (is_data ? OP_WDATA : OP_WADDR)
                                                         : (is_data ? OP_RDATA : OP_RADDR);
                                end else if (!acc_write) begin
                                    d.rdata = lane_ones(lst);
                                end
                            end
                            default: begin
                                if (!acc_write) d.rdata = BUS_W'(8'hFF);
                            end
                        endcase
                    end
                end
            end
            ST_CTRL: begin
                d.ctrl     = q.pend;
                d.ev_valid = 1'b1;
                d.ev_kind  = EV_CTRL;
                d.ev_byte  = q.pend;
                d.done     = 1'b1;
                d.st       = ST_IDLE;
            end
            ST_XFER: begin
                if (eng_fin) begin
                    if (eng_ok) begin
                        nb[{q.idx, 3'b000} +: 8] = eng_rbyte;
                        d.rbuf = nb;
                    end else begin
                        d.tmo = 1'b1;
                    end
                    if (eng_ok && (q.idx != q.last)) begin
                        d.idx    = q.idx + 1'b1;
                        d.launch = 1'b1;
                    end else begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = q.rd ? (nb & lane_ones(q.last)) : '0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign acc_wait  = (q.st != ST_IDLE);
    assign acc_done  = q.done;
    assign acc_rdata = q.rdata;
    assign pp_req    = eng_req;
    assign pp_op     = q.op;
    assign pp_wbyte  = q.wbuf[{q.idx, 3'b000} +: 8];
    assign ev_valid  = q.ev_valid;
    assign ev_kind   = q.ev_kind;
    assign ev_byte   = q.ev_byte;
    assign ctrl_reg  = q.ctrl;
    assign tmo_flag  = q.tmo;
endmodule

// File: rtl/epp_gate_ctrl_chk.sv
module epp_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_req,
    input logic       acc_write,
    input logic       acc_win,
    input logic [2:0] acc_addr,
    input logic       acc_wbit0,
    input logic       acc_wait,
    input logic       pp_req,
    input logic       pp_ack,
    input logic [1:0] pp_op,
    input logic [7:0] pp_wbyte,
    input logic       ev_valid,
    input logic [1:0] ev_kind,
    input logic [7:0] ctrl_reg,
    input logic       tmo_flag
);
    p_gate_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pp_req) && !pp_op[1]) |-> ((ctrl_reg & 8'h2F) == 8'h04));

    p_gate_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pp_req) && pp_op[1]) |-> ((ctrl_reg & 8'h2F) == 8'h24));

    p_ack_ends_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_req && pp_ack) |=> !pp_req);

    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_req && $past(pp_req)) |-> ($stable(pp_op) && $stable(pp_wbyte)));

    p_tmo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmo_flag) |-> $past(acc_req && acc_write && !acc_win &&
                                  acc_addr == 3'd1 && acc_wbit0 && !acc_wait));

    p_dir_then_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 2'd2) |=> (ev_valid && ev_kind == 2'd1));

    p_idle_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wait |-> !pp_req);
endmodule

bind epp_gate_ctrl epp_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .acc_write (acc_write),
    .acc_win   (acc_win),
    .acc_addr  (acc_addr),
    .acc_wbit0 (acc_wdata[0]),
    .acc_wait  (acc_wait),
    .pp_req    (pp_req),
    .pp_ack    (pp_ack),
    .pp_op     (pp_op),
    .pp_wbyte  (pp_wbyte),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ctrl_reg  (ctrl_reg),
    .tmo_flag  (tmo_flag)
);

// File: tb/test_epp_gate_ctrl.sv
module test_epp_gate_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tmo_limit = 8'd8;
    logic        acc_req = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_win = 1'b0;
    logic [2:0]  acc_addr = 3'd0;
    logic [1:0]  acc_size = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic        acc_wait, acc_done;
    logic [31:0] acc_rdata;
    logic [7:0]  pin_status = 8'hF7;
    logic        pp_req;
    logic [1:0]  pp_op;
    logic [7:0]  pp_wbyte;
    logic        pp_ack = 1'b0;
    logic [7:0]  pp_rdata = 8'h00;
    logic        ev_valid;
    logic [1:0]  ev_kind;
    logic [7:0]  ev_byte;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_rd[$];
    string       exp_rd_tag[$];
    logic [9:0]  exp_x[$];
    string       exp_x_tag[$];
    logic [9:0]  exp_ev[$];
    logic [7:0]  rd_bytes[$];

    int ack_delay = 2;
    int ack_cap   = 1000000;
    int acks_total = 0;

    epp_gate_ctrl i_epp_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .tmo_limit(tmo_limit),
        .acc_req(acc_req), .acc_write(acc_write), .acc_win(acc_win),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_wait(acc_wait), .acc_done(acc_done), .acc_rdata(acc_rdata),
        .pin_status(pin_status), .pp_req(pp_req), .pp_op(pp_op),
        .pp_wbyte(pp_wbyte), .pp_ack(pp_ack), .pp_rdata(pp_rdata),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte)
    );

    always #5 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected completion, issues the access, waits for done
    task automatic bus(input logic w, input logic win, input logic [2:0] addr,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input logic [31:0] exp, input string tag, input logic exp_wait);
        exp_rd.push_back(exp);
        exp_rd_tag.push_back(tag);
        @(negedge clk);
        acc_req = 1'b1; acc_write = w; acc_win = win;
        acc_addr = addr; acc_size = sz; acc_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        acc_req = 1'b0;
        check(acc_wait == exp_wait, "R12 acc_wait after accept", 32'(acc_wait), 32'(exp_wait));
        while (!acc_done) @(negedge clk);
    endtask

    task automatic exp_xfer(input logic [1:0] op, input logic [7:0] b, input string tag);
        exp_x.push_back({op, b});
        exp_x_tag.push_back(tag);
    endtask

    // Monitor: completions
    always @(negedge clk) begin
        if (rst_n && acc_done) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R12 unexpected completion", acc_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_rd.pop_front();
                t = exp_rd_tag.pop_front();
                check(acc_rdata == e, t, acc_rdata, e);
                check(!acc_wait, "R12 wait low at completion", 32'(acc_wait), 32'h0);
            end
        end
    end

    // Monitor: events
    always @(negedge clk) begin
        if (rst_n && ev_valid) begin
            if (exp_ev.size() == 0) begin
                check(1'b0, "R9/R10 unexpected event", {22'h0, ev_kind, ev_byte}, 32'h0);
            end else begin
                logic [9:0] e;
                e = exp_ev.pop_front();
                check({ev_kind, ev_byte} == e, "R9 R10 event", {22'h0, ev_kind, ev_byte},
                      {22'h0, e});
            end
        end
    end

    // Peripheral model and transfer monitor
    logic req_prev = 1'b0;
    logic acked = 1'b0;
    int   hi_cnt = 0;
    always @(negedge clk) begin
        if (pp_req && !req_prev) begin
            hi_cnt = 0;
            acked  = 1'b0;
            if (exp_x.size() == 0) begin
                check(1'b0, "R2 R8 unexpected request", {22'h0, pp_op, pp_wbyte}, 32'h0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_x.pop_front();
                t = exp_x_tag.pop_front();
                check({pp_op, pp_wbyte} == e, t, {22'h0, pp_op, pp_wbyte}, {22'h0, e});
            end
        end
        if (!pp_req && req_prev && !acked)
            check(hi_cnt == int'(tmo_limit), "R4 request length on timeout",
                  32'(hi_cnt), 32'(tmo_limit));
        if (pp_req) hi_cnt++;
        pp_ack = 1'b0;
        if (pp_req && !acked && acks_total < ack_cap && hi_cnt >= ack_delay) begin
            pp_ack   = 1'b1;
            pp_rdata = (rd_bytes.size() > 0) ? rd_bytes.pop_front() : 8'h00;
            acked    = 1'b1;
            acks_total++;
        end
        req_prev = pp_req;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values, R6 status bit0 replaced
        bus(0, 0, 3'd2, 0, 0, 32'hCC, "R1 control after reset", 0);
        bus(0, 0, 3'd0, 0, 0, 32'hFF, "R1 data after reset", 0);
        bus(0, 0, 3'd1, 0, 0, 32'hF6, "R1 R6 status after reset", 0);
        // R2 / R3 gate refusals with control 0xCC
        bus(1, 0, 3'd3, 0, 32'h5A, 32'h0, "R2 addr write dropped", 0);
        bus(1, 0, 3'd4, 2, 32'h11223344, 32'h0, "R2 data write dropped", 0);
        bus(0, 0, 3'd4, 0, 0, 32'hFF, "R3 refused read width 1", 0);
        bus(0, 0, 3'd4, 1, 0, 32'hFFFF, "R3 refused read width 2", 0);
        bus(0, 0, 3'd4, 3, 0, 32'hFFFFFFFF, "R3 refused read width 4", 0);
        bus(0, 1, 3'd4, 0, 0, 32'hFF, "R11 window read", 0);
        // R10 control write without direction change, then repeat
        exp_ev.push_back({2'd1, 8'hC4});
        bus(1, 0, 3'd2, 0, 32'h04, 32'h0, "R10 control write", 0);
        bus(1, 0, 3'd2, 0, 32'h04, 32'h0, "R10 equal control write", 0);
        bus(0, 0, 3'd2, 0, 0, 32'hC4, "R10 control readback", 0);
        // R4 / R7 write transfers
        exp_xfer(2'd1, 8'hA5, "R4 single data byte");
        bus(1, 0, 3'd4, 0, 32'h000000A5, 32'h0, "R4 write done", 1);
        ack_delay = 3;
        exp_xfer(2'd1, 8'h34, "R7 width2 byte0");
        exp_xfer(2'd1, 8'h12, "R7 width2 byte1");
        bus(1, 0, 3'd4, 1, 32'h00001234, 32'h0, "R7 width2 write done", 1);
        exp_xfer(2'd0, 8'hEF, "R7 address port one byte");
        bus(1, 0, 3'd3, 1, 32'h0000BEEF, 32'h0, "R7 address write done", 1);
        exp_xfer(2'd1, 8'hEF, "R7 width4 byte0");
        exp_xfer(2'd1, 8'hBE, "R7 width4 byte1");
        exp_xfer(2'd1, 8'hAD, "R7 width4 byte2");
        exp_xfer(2'd1, 8'hDE, "R7 width4 byte3");
        bus(1, 0, 3'd4, 2, 32'hDEADBEEF, 32'h0, "R7 width4 write done", 1);
        // R8 / R5 failure mid write
        ack_cap = acks_total + 1;
        exp_xfer(2'd1, 8'h01, "R8 byte before failure");
        exp_xfer(2'd1, 8'h02, "R8 failing byte");
        bus(1, 0, 3'd4, 2, 32'h04030201, 32'h0, "R8 failed write done", 1);
        ack_cap = 1000000;
        bus(0, 0, 3'd1, 0, 0, 32'hF7, "R5 R6 timeout in status", 0);
        bus(1, 0, 3'd1, 0, 32'h00, 32'h0, "R5 status write bit0 clear", 0);
        bus(0, 0, 3'd1, 0, 0, 32'hF7, "R5 flag kept", 0);
        bus(1, 0, 3'd1, 0, 32'h01, 32'h0, "R5 status write bit0 set", 0);
        bus(0, 0, 3'd1, 0, 0, 32'hF6, "R5 flag cleared", 0);
        // R10 direction change to read mode
        exp_ev.push_back({2'd2, 8'h01});
        exp_ev.push_back({2'd1, 8'hE4});
        bus(1, 0, 3'd2, 0, 32'h24, 32'h0, "R10 direction change", 1);
        bus(0, 0, 3'd2, 0, 0, 32'hE4, "R10 control after direction", 0);
        // R3 / R7 reads
        rd_bytes.push_back(8'h11); rd_bytes.push_back(8'h22);
        rd_bytes.push_back(8'h33); rd_bytes.push_back(8'h44);
        for (int i = 0; i < 4; i++) exp_xfer(2'd3, 8'h00, "R4 R7 data read byte");
        bus(0, 0, 3'd4, 2, 0, 32'h44332211, "R3 R7 width4 read", 1);
        rd_bytes.push_back(8'h77);
        exp_xfer(2'd2, 8'h00, "R4 address read");
        bus(0, 0, 3'd3, 2, 0, 32'h77, "R3 R7 address read", 1);
        // R8 failed read
        ack_cap = acks_total + 1;
        rd_bytes.push_back(8'h99);
        exp_xfer(2'd3, 8'h00, "R8 read byte0");
        exp_xfer(2'd3, 8'h00, "R8 read failing byte");
        bus(0, 0, 3'd4, 2, 0, 32'hFFFFFF99, "R8 partial read", 1);
        ack_cap = 1000000;
        bus(0, 0, 3'd1, 0, 0, 32'hF7, "R5 timeout after read", 0);
        bus(1, 0, 3'd1, 0, 32'hFF, 32'h0, "R5 clear again", 0);
        bus(1, 0, 3'd4, 0, 32'h55, 32'h0, "R2 write in read mode dropped", 0);
        // back to write mode, read now refused
        exp_ev.push_back({2'd2, 8'h00});
        exp_ev.push_back({2'd1, 8'hC4});
        bus(1, 0, 3'd2, 0, 32'h04, 32'h0, "R10 direction back", 1);
        bus(0, 0, 3'd3, 0, 0, 32'hFF, "R3 address read refused", 0);
        // R9 data register
        exp_ev.push_back({2'd0, 8'h3C});
        bus(1, 0, 3'd0, 0, 32'h3C, 32'h0, "R9 data write", 0);
        bus(1, 0, 3'd0, 0, 32'h3C, 32'h0, "R9 equal data write", 0);
        bus(0, 0, 3'd0, 0, 0, 32'h3C, "R9 data readback", 0);
        // R11 window writes ignored
        bus(1, 1, 3'd0, 0, 32'h00, 32'h0, "R11 window write data", 0);
        bus(1, 1, 3'd2, 0, 32'h20, 32'h0, "R11 window write control", 0);
        bus(0, 0, 3'd0, 0, 0, 32'h3C, "R11 data unchanged", 0);
        bus(0, 0, 3'd2, 0, 0, 32'hC4, "R11 control unchanged", 0);
        repeat (4) @(negedge clk);
        check(exp_x.size() == 0, "R4 pending transfers", 32'(exp_x.size()), 32'h0);
        check(exp_ev.size() == 0, "R10 pending events", 32'(exp_ev.size()), 32'h0);
        check(exp_rd.size() == 0, "R12 pending completions", 32'(exp_rd.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R12 actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule